// File: doc/BRIEF.md
# Event-to-Interrupt Selector Mux

This block picks, for each of a small set of CPU interrupt inputs, one line out of a wide bank of event lines and presents it to the CPU. There are 12 outputs by default. Output k feeds CPU interrupt priority k+4, so together they cover priorities 4 through 15. Each output has its own 8-bit source selector. Sources 0 to 3 are the group-combined events produced by an upstream combiner. Sources 4 to 127 are individual events. The block does not latch events and does not resolve CPU priority. It only selects and registers the chosen line.

The selectors sit four to a 32-bit word behind a simple word-addressed register bus with a write strobe and a combinational read path. Word 0 is a placeholder that holds nothing. Words 1 to 3 hold the selectors. Reads return the programmed values, so software can change one field by reading the word, editing one byte and writing the word back. A selector value that names no existing event forces its output low.

Top module: `evt_irq_selmux`

## Requirements
- R1: After reset, the selector of output k holds k+4, so word 1 reads 0x07060504, word 2 reads 0x0B0A0908 and word 3 reads 0x0F0E0D0C. While the event inputs stay low, every output is low.
- R2: The selector of output k sits in word 1+k/4, bits [(k mod 4)*8+7 : (k mod 4)*8]. A write to word 1, 2 or 3 replaces all four fields of that word. A read of that word returns the current fields in the same positions, in the same cycle as the address.
- R3: When the selector value s of output k is below 128, bit k of the output (CPU priority k+4) equals event line s as sampled at the previous rising clock edge.
- R4: When the selector value of output k is 128 or more, output k is 0 whatever the events are.
- R5: A write to word 0, or to any address above word 3, changes no selector and no output. A read of those addresses returns 0.
- R6: A change on an event input, or a new selector value, appears on the outputs at the first rising edge after the edge that captured it. It never appears earlier.
- R7: Every output can select any source from 0 to 127, including the combined sources 0 to 3, and they behave the same as individual events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_EVT (128) | Event lines. Bits 0 to 3 are the combined group events |
| bus_addr_i | input | ADDR_W (3) | Word address of the register bus |
| bus_wr_i | input | 1 | Write strobe. The word is written at the rising edge |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data for the word at bus_addr_i, combinational |
| irq_o | output | N_OUT (12) | Registered outputs. Bit k drives CPU interrupt priority k+4 |

## Verification
The bench sweeps a base selector value over all 256 codes. For each one it programs the 12 outputs with different offsets of that base, so every source number, the combined sources 0 to 3, and every out-of-range code each meet each output position at least once. Each configuration is tried with a scrambled 128-bit event pattern and then with its bitwise complement. The pair tells a correct routing from an output stuck at a constant, and from a selector that picks a neighbouring line or the wrong field. Separate steps drive the reset image, writes to the unused and unmapped addresses, and event and selector changes sampled just before and just after a clock edge. These steps separate correct register placement and one-cycle latency from a read path with an offset and from a combinational leak.

// File: rtl/eisel_pkg.sv
package eisel_pkg;

   // Kind of a register-bus word address
   typedef enum logic [1:0] {
      WK_PLACEHOLDER = 2'd0,
      WK_SELECTOR    = 2'd1,
      WK_UNMAPPED    = 2'd2
   } word_kind_e;

   // Word 0 is a placeholder; words 1..n_words hold selectors
   function automatic word_kind_e decode_word(input int addr, input int n_words);
      if (addr == 0)
         return WK_PLACEHOLDER;
      else if (addr <= n_words)
         return WK_SELECTOR;
      else
         return WK_UNMAPPED;
   endfunction

endpackage

// File: rtl/eisel_regbank.sv
module eisel_regbank
   import eisel_pkg::*;
#(
   parameter int N_OUT    = 12,
   parameter int SEL_W    = 8,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 3,
   parameter int RST_BASE = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr_i,
   input  logic                     bus_wr_i,
   input  logic [DATA_W-1:0]        bus_wdata_i,
   output logic [DATA_W-1:0]        bus_rdata_o,
   output logic [N_OUT*SEL_W-1:0]   sel_flat_o
);

   localparam int FPW     = DATA_W / SEL_W;
   localparam int N_WORDS = N_OUT / FPW;
   localparam int FLAT_W  = N_OUT * SEL_W;

   // Reset image: output k selects source k + RST_BASE
   function automatic logic [FLAT_W-1:0] reset_image();
      logic [FLAT_W-1:0] v;
      v = '0;
      for (int k = 0; k < N_OUT; k++)
         v[k*SEL_W +: SEL_W] = SEL_W'(k + RST_BASE);
      return v;
   endfunction

   localparam logic [FLAT_W-1:0] RST_IMAGE = reset_image();

   logic [FLAT_W-1:0] sel_q;
   word_kind_e        addr_kind;

   assign addr_kind = decode_word(int'(bus_addr_i), N_WORDS);

   // Whole-word writes; placeholder and unmapped words are dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= RST_IMAGE;
      end else if (bus_wr_i && addr_kind == WK_SELECTOR) begin
         for (int w = 0; w < N_WORDS; w++) begin
            if (int'(bus_addr_i) == w + 1)
               sel_q[w*DATA_W +: DATA_W] <= bus_wdata_i;
         end
      end
   end

   // Combinational read, zero outside the selector words
   always_comb begin
      bus_rdata_o = '0;
      if (addr_kind == WK_SELECTOR) begin
         for (int w = 0; w < N_WORDS; w++) begin
            if (int'(bus_addr_i) == w + 1)
               bus_rdata_o = sel_q[w*DATA_W +: DATA_W];
         end
      end
   end

   assign sel_flat_o = sel_q;

endmodule

// File: rtl/eisel_route.sv
module eisel_route #(
   parameter int N_EVT   = 128,
   parameter int N_OUT   = 12,
   parameter int SEL_W   = 8,
   parameter int REG_OUT = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_EVT-1:0]         evt_i,
   input  logic [N_OUT*SEL_W-1:0]   sel_flat_i,
   output logic [N_OUT-1:0]         irq_o
);

   localparam int IDX_W = $clog2(N_EVT);

   logic [N_OUT-1:0] pick;

   generate
      for (genvar k = 0; k < N_OUT; k++) begin : g_lane
         logic [SEL_W-1:0] s_k;
         logic             in_range;
         assign s_k      = sel_flat_i[k*SEL_W +: SEL_W];
         assign in_range = (32'(s_k) < N_EVT);
         assign pick[k]  = in_range ? evt_i[s_k[IDX_W-1:0]] : 1'b0;
      end

      if (REG_OUT != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               irq_o <= '0;
            else
               irq_o <= pick;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq_o = pick;
      end
   endgenerate

endmodule

// File: rtl/evt_irq_selmux.sv
module evt_irq_selmux #(
   parameter int N_EVT    = 128,
   parameter int N_OUT    = 12,
   parameter int SEL_W    = 8,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 3,
   parameter int RST_BASE = 4,
   parameter int REG_OUT  = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_EVT-1:0]    evt_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic                bus_wr_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   output logic [DATA_W-1:0]   bus_rdata_o,
   output logic [N_OUT-1:0]    irq_o
);

   localparam int FPW     = DATA_W / SEL_W;
   localparam int N_WORDS = N_OUT / FPW;

   // Elaboration-time parameter checks
   generate
      if (N_EVT < 2 || N_EVT > (1 << SEL_W)) begin : g_bad_evt
         $error("N_EVT must lie between 2 and 2**SEL_W");
      end
      if (DATA_W % SEL_W != 0) begin : g_bad_pack
         $error("DATA_W must be a whole multiple of SEL_W");
      end
      if (N_OUT % FPW != 0) begin : g_bad_out
         $error("N_OUT must fill whole selector words");
      end
      if ((1 << ADDR_W) < N_WORDS + 1) begin : g_bad_addr
         $error("ADDR_W too narrow for placeholder plus selector words");
      end
   endgenerate

   logic [N_OUT*SEL_W-1:0] sel_flat;

   eisel_regbank #(
      .N_OUT    (N_OUT),
      .SEL_W    (SEL_W),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .RST_BASE (RST_BASE)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr_i  (bus_addr_i),
      .bus_wr_i    (bus_wr_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o),
      .sel_flat_o  (sel_flat)
   );

   eisel_route #(
      .N_EVT   (N_EVT),
      .N_OUT   (N_OUT),
      .SEL_W   (SEL_W),
      .REG_OUT (REG_OUT)
   ) u_route (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_i),
      .sel_flat_i (sel_flat),
      .irq_o      (irq_o)
   );

endmodule

// File: rtl/eisel_checker.sv
module eisel_checker #(
   parameter int N_EVT   = 128,
   parameter int N_OUT   = 12,
   parameter int SEL_W   = 8,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 3,
   parameter int REG_OUT = 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [N_EVT-1:0]        evt_i,
   input logic [ADDR_W-1:0]       bus_addr_i,
   input logic                    bus_wr_i,
   input logic [DATA_W-1:0]       bus_wdata_i,
   input logic [DATA_W-1:0]       bus_rdata_o,
   input logic [N_OUT-1:0]        irq_o,
   input logic [N_OUT*SEL_W-1:0]  sel_flat
);

   localparam int FPW     = DATA_W / SEL_W;
   localparam int N_WORDS = N_OUT / FPW;

   function automatic logic model_pick(input logic [N_EVT-1:0] e, input logic [SEL_W-1:0] s);
      if (32'(s) >= N_EVT)
         return 1'b0;
      for (int i = 0; i < N_EVT; i++)
         if (32'(s) == i)
            return e[i];
      return 1'b0;
   endfunction

   // R5: placeholder word reads zero
   a_r5_placeholder_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_i == '0) |-> (bus_rdata_o == '0));

   // R5: placeholder write leaves every selector alone
   a_r5_placeholder_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == '0) |=> $stable(sel_flat));

   generate
      for (genvar w = 0; w < N_WORDS; w++) begin : g_word
         // R2: a selector word takes the written value
         a_r2_word_write: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_i && int'(bus_addr_i) == w + 1)
            |=> (sel_flat[w*DATA_W +: DATA_W] == $past(bus_wdata_i)));
      end

      if (REG_OUT != 0) begin : g_lat
         for (genvar k = 0; k < N_OUT; k++) begin : g_out
            // R6 / R3: output follows previous-edge event and selector
            a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
               1'b1 |=> (irq_o[k] == model_pick($past(evt_i), $past(sel_flat[k*SEL_W +: SEL_W]))));
            // R4: out-of-range selector forces the output low
            a_r4_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
               (32'(sel_flat[k*SEL_W +: SEL_W]) >= N_EVT) |=> !irq_o[k]);
         end
      end
   endgenerate

endmodule

bind evt_irq_selmux eisel_checker #(
   .N_EVT   (N_EVT),
   .N_OUT   (N_OUT),
   .SEL_W   (SEL_W),
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_i       (evt_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wr_i    (bus_wr_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rdata_o (bus_rdata_o),
   .irq_o       (irq_o),
   .sel_flat    (sel_flat)
);

// File: tb/tb_evt_irq_selmux.sv
module tb_evt_irq_selmux;

   localparam int CLK_PERIOD = 10;
   localparam int NE = 128;
   localparam int NO = 12;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NE-1:0]  evt = '0;
   logic [2:0]     bus_addr = '0;
   logic           bus_wr = 1'b0;
   logic [31:0]    bus_wdata = '0;
   logic [31:0]    bus_rdata;
   logic [NO-1:0]  irq;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   logic [7:0] sel_m [NO];

   evt_irq_selmux dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt),
      .bus_addr_i  (bus_addr),
      .bus_wr_i    (bus_wr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .irq_o       (irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NO-1:0] exp_irq(input logic [NE-1:0] e);
      logic [NO-1:0] v;
      for (int k = 0; k < NO; k++)
         v[k] = (sel_m[k] < 8'd128) ? e[sel_m[k][6:0]] : 1'b0;
      return v;
   endfunction

   function automatic logic [31:0] model_word(input int w);
      return {sel_m[4*w+3], sel_m[4*w+2], sel_m[4*w+1], sel_m[4*w]};
   endfunction

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      if (a >= 3'd1 && a <= 3'd3)
         for (int f = 0; f < 4; f++)
            sel_m[4*(int'(a)-1)+f] = d[8*f +: 8];
   endtask

   task automatic read_check(input logic [2:0] a, input logic [31:0] exp, input string req);
      bus_addr = a;
      #1;
      check(bus_rdata == exp, req, 128'(bus_rdata), 128'(exp));
   endtask

   task automatic drive_and_check(input logic [NE-1:0] e);
      logic [NO-1:0] ex;
      evt = e;
      ex = exp_irq(e);
      @(negedge clk);
      for (int k = 0; k < NO; k++) begin
         if (sel_m[k] >= 8'd128)
            check(irq[k] == ex[k], "R4 out-of-range selector", 128'(irq[k]), 128'(ex[k]));
         else if (sel_m[k] < 8'd4)
            check(irq[k] == ex[k], "R7 combined source", 128'(irq[k]), 128'(ex[k]));
         else
            check(irq[k] == ex[k], "R3 routing", 128'(irq[k]), 128'(ex[k]));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fails++;
         n_checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      logic [NO-1:0] old_ex;
      logic [NE-1:0] pat;
      for (int k = 0; k < NO; k++) sel_m[k] = 8'(k + 4);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset image and quiet outputs
      read_check(3'd1, 32'h07060504, "R1 reset word1");
      read_check(3'd2, 32'h0B0A0908, "R1 reset word2");
      read_check(3'd3, 32'h0F0E0D0C, "R1 reset word3");
      check(irq == '0, "R1 outputs low", 128'(irq), 128'(0));
      // R1: default routing takes events 4..15
      drive_and_check(NE'(128'h0000_0000_0000_0000_0000_0000_0000_A5A0));
      drive_and_check(NE'(128'h0000_0000_0000_0000_0000_0000_0000_5A50));

      // R2 / R3 / R4 / R7: sweep base selector over all codes
      for (int s = 0; s < 256; s++) begin
         for (int w = 0; w < 3; w++) begin
            logic [31:0] d;
            for (int f = 0; f < 4; f++)
               d[8*f +: 8] = 8'((s + 37 * (4*w + f)) & 255);
            bus_write(3'(w + 1), d);
         end
         for (int w = 0; w < 3; w++)
            read_check(3'(w + 1), model_word(w), "R2 readback");
         pat = {32'(s) * 32'h9E3779B1, ~(32'(s) * 32'h85EBCA6B),
                (32'(s) * 32'hC2B2AE35) ^ 32'h5BD1E995, 32'h27D4EB2F + 32'(s)};
         drive_and_check(pat);
         drive_and_check(~pat);
      end

      // R2: single-field read-modify-write
      begin
         logic [31:0] rd;
         bus_addr = 3'd2; #1; rd = bus_rdata;
         rd[15:8] = 8'd2;
         bus_write(3'd2, rd);
         read_check(3'd2, rd, "R2 read-modify-write");
         check(sel_m[5] == 8'd2, "R2 field position", 128'(sel_m[5]), 128'(2));
      end

      // R5: placeholder and unmapped addresses
      pat = {4{32'hC3A5_965A}};
      drive_and_check(pat);
      old_ex = exp_irq(pat);
      for (int a = 0; a < 8; a++) begin
         if (a == 0 || a > 3) begin
            bus_write(3'(a), 32'hFFFF_FFFF);
            read_check(3'(a), 32'h0, "R5 unused read zero");
            check(irq == old_ex, "R5 outputs unchanged", 128'(irq), 128'(old_ex));
         end
      end
      for (int w = 0; w < 3; w++)
         read_check(3'(w + 1), model_word(w), "R5 selectors unchanged");

      // R6: event change latency
      bus_write(3'd1, 32'h03020100);
      bus_write(3'd2, 32'h7F7E7D7C);
      bus_write(3'd3, 32'h402010FF);
      drive_and_check('0);
      evt = '1;
      #1;
      check(irq == '0, "R6 no early event", 128'(irq), 128'(0));
      old_ex = exp_irq('1);
      @(negedge clk);
      check(irq == old_ex, "R6 event after one edge", 128'(irq), 128'(old_ex));

      // R6: selector change latency
      old_ex = exp_irq(evt);
      bus_write(3'd3, 32'h80808080);
      check(irq == old_ex, "R6 old selector until next edge", 128'(irq), 128'(old_ex));
      old_ex = exp_irq(evt);
      @(negedge clk);
      check(irq == old_ex, "R6 new selector after edge", 128'(irq), 128'(old_ex));

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule